// File: doc/BRIEF.md
# Jack Tip-Sense Debounce Filter

This block turns the raw output of a headphone-jack tip-sense comparator into a clean plug-status flag for interrupt logic. It can invert the incoming level first. After that, a high level means "plugged". The plugged state is reported as soon as the time base next ticks. The unplugged state is held back until the sensed level has stayed low for a selectable window.

The window is chosen by a 2-bit select input from four lengths: none, short, medium and long. These are nominally 0, 200, 500 and 1000 ms. The window is counted in ticks of an external time-base strobe, which is derived from the master clock. Because of this, the real durations scale with that clock. Whenever the debounced flag changes, the block raises a one-cycle pulse.

Top module: `jack_sense_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `plug_status` and `status_toggle` are both 0.
- R2: The sensed level is `sense_raw` XOR `sense_invert`. With `sense_invert` = 0 the raw level passes unchanged; with 1 it is inverted before any filtering.
- R3: On a clock edge where `tick_en` is 1 and the sensed level is 1, `plug_status` becomes 1 after that edge. This happens with no delay, and it abandons any unplug count in progress.
- R4: With `unplug_sel` = 2'b00 (no debounce), `plug_status` falls on the first tick on which the sensed level is 0.
- R5: With `unplug_sel` = 2'b01, 2'b10 or 2'b11, `plug_status` falls on the N-th consecutive tick with sensed level 0, and not before. N is `T_SHORT`, `T_MID` or `T_LONG` respectively, with defaults 200, 500 and 1000 ticks of a 1 ms strobe.
- R6: Any clock cycle with the sensed level at 1 restarts the unplug count, even when `tick_en` is 0 in that cycle.
- R7: `plug_status` changes only on edges where `tick_en` is 1.
- R8: `status_toggle` is 1 for exactly the one cycle in which `plug_status` holds a new value, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Time-base strobe, one cycle per debounce tick |
| sense_raw | input | 1 | Raw tip-sense comparator level |
| sense_invert | input | 1 | 1 inverts the raw level |
| unplug_sel | input | 2 | Unplug window: 00 none, 01 short, 10 medium, 11 long |
| plug_status | output | 1 | Debounced plug flag, 1 = plugged |
| status_toggle | output | 1 | One-cycle pulse when `plug_status` changes |

## Verification
The hardest case to reach is an unplug count that stops one tick short of its window and is then restarted. This can happen through a short high glitch that falls between ticks, or through a plug tick. The bench drives each tick explicitly. For every select value and both polarities, it walks the sensed level low for exactly N-1 ticks and then injects a glitch that lasts one cycle with no tick. It then proves that a further N-1 ticks still leave the flag high and that the N-th tick drops it.

// File: rtl/jsf_pkg.sv
package jsf_pkg;
    typedef enum logic [1:0] {
        WIN_NONE  = 2'b00,
        WIN_SHORT = 2'b01,
        WIN_MID   = 2'b10,
        WIN_LONG  = 2'b11
    } win_sel_e;
endpackage

// File: rtl/jsf_polarity.sv
module jsf_polarity (
    input  logic raw_in,
    input  logic invert,
    output logic sensed
);
    assign sensed = raw_in ^ invert;
endmodule

// File: rtl/jsf_window.sv
module jsf_window #(
    parameter int T_SHORT = 200,
    parameter int T_MID   = 500,
    parameter int T_LONG  = 1000,
    parameter int CNT_W   = 10
) (
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] limit
);
    import jsf_pkg::*;

    always_comb begin
        unique case (win_sel_e'(sel))
            WIN_NONE:  limit = '0;
            WIN_SHORT: limit = CNT_W'(T_SHORT);
            WIN_MID:   limit = CNT_W'(T_MID);
            default:   limit = CNT_W'(T_LONG);
        endcase
    end
endmodule

// File: rtl/jsf_core.sv
module jsf_core #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             sensed,
    input  logic [CNT_W-1:0] limit,
    output logic             status,
    output logic             toggle
);
    typedef struct packed {
        logic             status;
        logic             toggle;
        logic [CNT_W-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        if (sensed) begin
            st_d.cnt = '0;
            if (tick_en) st_d.status = 1'b1;
        end else if (!st_q.status) begin
            st_d.cnt = '0;
        end else if (tick_en) begin
            if (cnt_inc >= {1'b0, limit}) begin
                st_d.status = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = cnt_inc[CNT_W-1:0];
            end
        end
        st_d.toggle = (st_d.status != st_q.status);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;
    assign toggle = st_q.toggle;

    // R7
    status_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.status != $past(st_q.status)) |-> $past(tick_en));

    // R3
    plug_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && sensed) |=> st_q.status);

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sensed |=> (st_q.cnt == '0));

    // R8
    toggle_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.status != $past(st_q.status)) |-> st_q.toggle);

    // R4
    fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.status) |-> !$past(sensed));
endmodule

// File: rtl/jack_sense_filter.sv
module jack_sense_filter #(
    parameter int T_SHORT = 200,
    parameter int T_MID   = 500,
    parameter int T_LONG  = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       sense_raw,
    input  logic       sense_invert,
    input  logic [1:0] unplug_sel,
    output logic       plug_status,
    output logic       status_toggle
);
    localparam int T_MAX = (T_LONG > T_MID) ? ((T_LONG > T_SHORT) ? T_LONG : T_SHORT)
                                            : ((T_MID > T_SHORT) ? T_MID : T_SHORT);
    localparam int CNT_W = $clog2(T_MAX + 1);

    logic             sensed;
    logic [CNT_W-1:0] limit;

    jsf_polarity u_pol (
        .raw_in (sense_raw),
        .invert (sense_invert),
        .sensed (sensed)
    );

    jsf_window #(
        .T_SHORT (T_SHORT),
        .T_MID   (T_MID),
        .T_LONG  (T_LONG),
        .CNT_W   (CNT_W)
    ) u_win (
        .sel   (unplug_sel),
        .limit (limit)
    );

    jsf_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .sensed  (sensed),
        .limit   (limit),
        .status  (plug_status),
        .toggle  (status_toggle)
    );
endmodule

// File: tb/jack_sense_filter_bench.sv
module jack_sense_filter_bench;
    localparam int TS = 3;
    localparam int TM = 5;
    localparam int TL = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       sense_raw = 1'b0;
    logic       sense_invert = 1'b0;
    logic [1:0] unplug_sel = 2'b10;
    logic       plug_status;
    logic       status_toggle;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    jack_sense_filter #(.T_SHORT(TS), .T_MID(TM), .T_LONG(TL)) u_jack_sense_filter (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_en       (tick_en),
        .sense_raw     (sense_raw),
        .sense_invert  (sense_invert),
        .unplug_sel    (unplug_sel),
        .plug_status   (plug_status),
        .status_toggle (status_toggle)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick();
        tick_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic drive(input logic lvl);
        sense_raw = lvl ^ sense_invert;
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk("R1 status in reset", plug_status, 1'b0);
        chk("R1 toggle in reset", status_toggle, 1'b0);
        rst_n = 1'b1;
        idle();
        chk("R1 status after reset", plug_status, 1'b0);
        chk("R1 toggle after reset", status_toggle, 1'b0);

        for (int inv = 0; inv < 2; inv++) begin
            for (int sel = 0; sel < 4; sel++) begin
                int lim;
                int win;
                lim = (sel == 0) ? 0 : (sel == 1) ? TS : (sel == 2) ? TM : TL;
                win = (lim == 0) ? 1 : lim;
                sense_invert = inv[0];
                unplug_sel = sel[1:0];

                drive(1'b1);
                idle();
                idle();
                chk("R7 no change without tick", plug_status, 1'b0);
                tick();
                chk(inv ? "R2 R3 inverted plug" : "R3 plug at once", plug_status, 1'b1);
                chk("R8 toggle on plug", status_toggle, 1'b1);
                idle();
                chk("R8 toggle one cycle", status_toggle, 1'b0);

                drive(1'b0);
                for (int k = 1; k <= win; k++) begin
                    tick();
                    chk(lim == 0 ? "R4 no debounce" : "R5 window count",
                        plug_status, (k >= win) ? 1'b0 : 1'b1);
                    chk("R8 toggle on unplug", status_toggle, (k == win) ? 1'b1 : 1'b0);
                end
                idle();
                chk("R8 toggle cleared", status_toggle, 1'b0);

                if (lim >= 2) begin
                    drive(1'b1);
                    tick();
                    drive(1'b0);
                    for (int k = 1; k < lim; k++) tick();
                    chk("R5 short of window", plug_status, 1'b1);
                    drive(1'b1);
                    idle();
                    drive(1'b0);
                    for (int k = 1; k < lim; k++) tick();
                    chk("R6 glitch restarted count", plug_status, 1'b1);
                    drive(1'b1);
                    tick();
                    chk("R3 plug tick mid count", plug_status, 1'b1);
                    chk("R8 no toggle when unchanged", status_toggle, 1'b0);
                    drive(1'b0);
                    for (int k = 1; k < lim; k++) tick();
                    chk("R3 count restarted by plug tick", plug_status, 1'b1);
                    idle();
                    idle();
                    chk("R7 hold between ticks", plug_status, 1'b1);
                    tick();
                    chk("R5 falls at window end", plug_status, 1'b0);
                    chk("R8 toggle at window end", status_toggle, 1'b1);
                    idle();
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule